// File: doc/BRIEF.md
# Serial memory programming sequencer

The block copies a small boot image into a parallel SRAM or EEPROM over a narrow serial link. A sequencer reads each image byte from an internal ROM. It sends the byte's 16-bit target address and the byte itself as two serial bit streams that share one shift clock. A receiver of three 8-bit serial-in, parallel-out registers then presents the address and data to the memory. The receiver is modelled inside the same design: two address stages in a chain and one data stage. Once the parallel side is stable, the sequencer strobes the memory's chip-enable and write-enable lines.

Each receiver stage updates its output latch on the same edge that shifts it. The latched outputs therefore trail the shift contents by one edge, and the sequencer issues one extra clock pulse per byte to bring the last shifted state out. The data stage shares the address clock, so it sees the data byte twice per transfer and keeps the last eight bits. The image sits at the top 512 bytes of a 64K space and ends in the processor vector bytes. A bus-hold output keeps the processor off the memory bus for the whole run. A fill mode writes a constant to every location in place of the image.

Top module: `rom_loader_top`

## Requirements
- R1: After reset, ser_clk is 0, mem_we_n and mem_ce_n are 1, and bus_hold and done are 0. They stay that way until start is seen.
- R2: For every byte, ser_clk makes exactly 17 rising edges before the write strobe.
  - Edges 1 to 16 carry the address MSB first on ser_addr, high byte first, and the data byte MSB first on ser_data, twice.
  - Edge 17 is the compensating pulse.
  - The memory outputs at the strobe equal what a receiver of three 8-bit registers would present. In that receiver the latches load the pre-shift contents on each edge, and the high address byte sits in the far stage.
- R3: One run writes each address from 0xFE00 to 0xFFFF exactly once, in ascending order, and never writes below 0xFE00.
- R4: In image mode, the byte at offset i (address 0xFE00+i) is as follows:
  - Offsets 0, 1 and 2 hold 0x4C, 0x00 and 0xFE.
  - Offsets 506 to 511 hold 0x00 at even offsets and 0xFE at odd offsets, so the reset vector at 0xFFFC/0xFFFD reads 0xFE00.
  - Every other offset holds (37*i + 90) mod 256.
- R5: The write strobe drives mem_we_n and mem_ce_n low together.
  - While it is low, ser_clk is 0 and mem_addr and mem_data do not change.
  - They are also unchanged from the clock before the strobe falls.
- R6: Each write strobe is low for exactly 2 clocks.
- R7: bus_hold rises on the clock after start is accepted. It stays high through every write strobe and falls on the same clock as done.
- R8: done is high for exactly one clock per run, after the 512th write.
- R9: When fill_const is 1 at the accepted start, every location is written with 0x42. fill_const is sampled only at that start, and changing it during a run has no effect.
- R10: A start pulse during a run is ignored. The run continues without restarting, and it still ends with exactly 512 writes and one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the block is idle |
| fill_const | input | 1 | Selects constant fill instead of the image, sampled at start |
| ser_clk | output | 1 | Shared shift and latch clock of the serial link |
| ser_addr | output | 1 | Serial address bit |
| ser_data | output | 1 | Serial data bit |
| mem_addr | output | 16 | Latched address presented to the memory |
| mem_data | output | 8 | Latched data presented to the memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| bus_hold | output | 1 | Keeps the processor off the bus while high |
| done | output | 1 | One-clock pulse at the end of a run |

## Verification
The bench runs the full 512-byte sweep twice. The first run uses image mode, so every offset carries a different value. This separates address ordering faults, off-by-one latch lag and bit-order errors, because any of these lands a wrong byte at a known offset. The vector bytes and the reset vector are checked in this run. The second run uses constant fill, which shows that the mode is latched at start and that the data path honours it apart from the ROM.

During the first run the bench injects a second start and flips fill_const, to show that neither disturbs a run in progress. A reference model of the three tied-clock shift stages, built from the serial pins, is compared with the parallel outputs at every strobe. Strobe width, setup stability and the shift-clock level are checked at every strobe.

// File: rtl/rom_loader_pkg.sv
package rom_loader_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_GRAB,
    S_SLO,
    S_SHI,
    S_SETUP,
    S_WAIT,
    S_STRB,
    S_HOLD
  } seq_state_t;

  // Boot image contents: a jump-to-self at the start, the vector bytes at
  // the top, and a position-dependent pattern everywhere else.
  function automatic logic [7:0] img_byte(int unsigned idx, int unsigned depth,
                                          int unsigned base);
    logic [7:0] b;
    int unsigned rel;
    if (idx == 0) begin
      b = 8'h4C;
    end else if (idx == 1) begin
      b = base[7:0];
    end else if (idx == 2) begin
      b = base[15:8];
    end else if (idx >= depth - 6) begin
      rel = idx - (depth - 6);
      b = rel[0] ? base[15:8] : base[7:0];
    end else begin
      rel = (idx * 37 + 90) % 256;
      b = rel[7:0];
    end
    return b;
  endfunction

endpackage

// File: rtl/image_rom.sv
module image_rom #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE   = 32'hFE00,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import rom_loader_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      mem[i] = DATA_W'(img_byte(i, DEPTH, BASE));
    end
  end

  // Registered read so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/serial_sender.sv
module serial_sender #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH      = 512,
  parameter int unsigned BASE       = 32'hFE00,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned FILL_VALUE = 32'h42,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned PULSES  = ADDR_W + 1,
  localparam int unsigned PCNT_W  = $clog2(PULSES + 1),
  localparam int unsigned SCNT_W  = $clog2(STROBE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fill_mode,
  output logic [IDX_W-1:0]  rom_addr,
  input  logic [DATA_W-1:0] rom_q,
  output logic              ser_clk,
  output logic              ser_addr,
  output logic              ser_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              bus_hold,
  output logic              done
);
  import rom_loader_pkg::*;

  seq_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic              fill_q;
  logic [ADDR_W-1:0] a_sr;
  logic [DATA_W-1:0] d_sr;
  logic [PCNT_W-1:0] pcnt;
  logic [SCNT_W-1:0] scnt;

  assign rom_addr = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      fill_q   <= 1'b0;
      a_sr     <= '0;
      d_sr     <= '0;
      pcnt     <= '0;
      scnt     <= '0;
      ser_clk  <= 1'b0;
      ser_addr <= 1'b0;
      ser_data <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      bus_hold <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            idx      <= '0;
            fill_q   <= fill_mode;
            bus_hold <= 1'b1;
            st       <= S_FETCH;
          end
        end
        S_FETCH: st <= S_GRAB;
        S_GRAB: begin
          a_sr <= ADDR_W'(BASE) + ADDR_W'(idx);
          d_sr <= fill_q ? DATA_W'(FILL_VALUE) : rom_q;
          pcnt <= '0;
          st   <= S_SLO;
        end
        S_SLO: begin
          ser_clk  <= 1'b0;
          ser_addr <= a_sr[ADDR_W-1];
          ser_data <= d_sr[DATA_W-1];
          a_sr     <= {a_sr[ADDR_W-2:0], 1'b0};
          d_sr     <= {d_sr[DATA_W-2:0], d_sr[DATA_W-1]};
          st       <= S_SHI;
        end
        S_SHI: begin
          ser_clk <= 1'b1;
          if (pcnt == PCNT_W'(PULSES - 1)) begin
            st <= S_SETUP;
          end else begin
            pcnt <= pcnt + 1'b1;
            st   <= S_SLO;
          end
        end
        S_SETUP: begin
          ser_clk <= 1'b0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          mem_we_n <= 1'b0;
          mem_ce_n <= 1'b0;
          scnt     <= '0;
          st       <= S_STRB;
        end
        S_STRB: begin
          if (scnt == SCNT_W'(STROBE_CYC - 1)) begin
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
            st       <= S_HOLD;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (idx == IDX_W'(DEPTH - 1)) begin
            done     <= 1'b1;
            bus_hold <= 1'b0;
            st       <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sipo_stage.sv
module sipo_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] par
);
  logic [W-1:0] sreg;

  assign sout = sreg[W-1];

  // Latch and shift on the same edge: the latch takes the pre-shift value.
  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      par  <= '0;
    end else if (shift_en) begin
      par  <= sreg;
      sreg <= {sreg[W-2:0], sin};
    end
  end
endmodule

// File: rtl/serial_receiver.sv
module serial_receiver #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_BYTES = ADDR_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_addr,
  input  logic              ser_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  logic sclk_d;
  logic rise;
  logic [ADDR_BYTES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= ser_clk;
  end
  assign rise = ser_clk & ~sclk_d;

  // Stage 0 is nearest the serial input and ends up with the low byte.
  for (genvar g = 0; g < int'(ADDR_BYTES); g++) begin : g_addr
    logic sin_g;
    if (g == 0) begin : g_first
      assign sin_g = ser_addr;
    end else begin : g_next
      assign sin_g = chain[g-1];
    end
    sipo_stage #(.W(DATA_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .shift_en (rise),
      .sin      (sin_g),
      .sout     (chain[g]),
      .par      (mem_addr[g*DATA_W +: DATA_W])
    );
  end

  logic data_sout;
  sipo_stage #(.W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rise),
    .sin      (ser_data),
    .sout     (data_sout),
    .par      (mem_data)
  );

  logic unused_ok;
  assign unused_ok = ^{data_sout, chain[ADDR_BYTES-1]};
endmodule

// File: rtl/rom_loader_top.sv
module rom_loader_top #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH      = 512,
  parameter int unsigned BASE       = 32'hFE00,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned FILL_VALUE = 32'h42,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fill_const,
  output logic              ser_clk,
  output logic              ser_addr,
  output logic              ser_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              bus_hold,
  output logic              done
);
  logic [IDX_W-1:0]  rom_addr;
  logic [DATA_W-1:0] rom_q;

  image_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BASE(BASE)) u_rom (
    .clk     (clk),
    .rd_addr (rom_addr),
    .rd_data (rom_q)
  );

  serial_sender #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BASE(BASE),
    .STROBE_CYC(STROBE_CYC), .FILL_VALUE(FILL_VALUE)
  ) u_send (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fill_mode (fill_const),
    .rom_addr  (rom_addr),
    .rom_q     (rom_q),
    .ser_clk   (ser_clk),
    .ser_addr  (ser_addr),
    .ser_data  (ser_data),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .bus_hold  (bus_hold),
    .done      (done)
  );

  serial_receiver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_recv (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_addr (ser_addr),
    .ser_data (ser_data),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
  );
endmodule

// File: rtl/rom_loader_chk.sv
module rom_loader_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE   = 32'hFE00
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_clk,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              bus_hold,
  input logic              done
);
  AST_CE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n); // R5
  AST_NO_SHIFT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !ser_clk); // R5
  AST_BUS_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_data))); // R5
  AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |=> !mem_we_n); // R6
  AST_WRITE_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_addr >= ADDR_W'(BASE))); // R3
  AST_HOLD_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> bus_hold); // R7
  AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_hold); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

bind rom_loader_top rom_loader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_clk  (ser_clk),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .bus_hold (bus_hold),
  .done     (done)
);

// File: tb/rom_loader_top_test.sv
`timescale 1ns/1ps
module rom_loader_top_test;
  localparam int DEPTH = 512;
  localparam int BASE  = 'hFE00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic fill_const = 1'b0;
  logic ser_clk, ser_addr, ser_data;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic mem_ce_n, mem_we_n, bus_hold, done;

  always #2 clk = ~clk;

  rom_loader_top uut (
    .clk(clk), .rst(rst), .start(start), .fill_const(fill_const),
    .ser_clk(ser_clk), .ser_addr(ser_addr), .ser_data(ser_data),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .bus_hold(bus_hold), .done(done)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input bit fill);
    if (fill) return 8'h42;
    if (i == 0) return 8'h4C;
    if (i == 1) return 8'h00;
    if (i == 2) return 8'hFE;
    if (i >= DEPTH - 6) return (i % 2 == 0) ? 8'h00 : 8'hFE;
    return 8'((i * 37 + 90) % 256);
  endfunction

  // Reference receiver and behavioural memory.
  logic [15:0] bsh_a = '0, blat_a = '0;
  logic [7:0]  bsh_d = '0, blat_d = '0;
  logic        prev_sclk = 1'b0, prev_we = 1'b1, prev_done = 1'b0;
  logic [15:0] prev_addr = '0;
  logic [7:0]  prev_data = '0;
  int rises = 0, wlow = 0, exp_idx = 0, done_cnt = 0;
  bit run_fill = 1'b0;
  logic [7:0] bmem [DEPTH];
  int wcount [DEPTH];

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !prev_sclk) begin
        blat_a = bsh_a; bsh_a = {bsh_a[14:0], ser_addr};
        blat_d = bsh_d; bsh_d = {bsh_d[6:0], ser_data};
        rises++;
      end
      if (!mem_we_n) begin
        wlow++;
        chk(!ser_clk, "R5 ser_clk low in strobe", ser_clk, 0);
        chk(!mem_ce_n, "R5 ce with we", mem_ce_n, 0);
        chk(mem_addr == prev_addr && mem_data == prev_data,
            "R5 bus stable", mem_addr, prev_addr);
        chk(bus_hold, "R7 hold in strobe", bus_hold, 1);
      end
      if (!mem_we_n && prev_we) begin
        chk(rises == 17, "R2 edges per byte", rises, 17);
        chk(mem_addr == blat_a, "R2 addr vs shift model", mem_addr, blat_a);
        chk(mem_data == blat_d, "R2 data vs shift model", mem_data, blat_d);
        chk(mem_addr == 16'(BASE + exp_idx), "R3 ascending address",
            mem_addr, BASE + exp_idx);
        chk(mem_data == exp_byte(exp_idx, run_fill), "R4/R9 write data",
            mem_data, exp_byte(exp_idx, run_fill));
        if (mem_addr >= 16'(BASE)) begin
          bmem[int'(mem_addr) - BASE] = mem_data;
          wcount[int'(mem_addr) - BASE]++;
        end
        exp_idx++;
        rises = 0;
      end
      if (mem_we_n && !prev_we) begin
        chk(wlow == 2, "R6 strobe width", wlow, 2);
        wlow = 0;
      end
      if (done) begin
        done_cnt++;
        chk(!bus_hold, "R7 release with done", bus_hold, 0);
        chk(exp_idx == DEPTH, "R8 done after last write", exp_idx, DEPTH);
      end
      chk(!(done && prev_done), "R8 done one clock", done, 0);
      prev_sclk = ser_clk; prev_we = mem_we_n; prev_done = done;
      prev_addr = mem_addr; prev_data = mem_data;
    end
  end

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) begin
      bmem[i] = 8'h00;
      wcount[i] = 0;
    end
    exp_idx = 0; done_cnt = 0; rises = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic verify_image(input bit fill, input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      chk(wcount[i] == 1, "R3 written once", wcount[i], 1);
      chk(bmem[i] == exp_byte(i, fill), tag, bmem[i], exp_byte(i, fill));
    end
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    clear_model();
    repeat (5) @(negedge clk);
    chk(!ser_clk && mem_we_n && mem_ce_n && !bus_hold && !done,
        "R1 reset state", {ser_clk, mem_we_n, mem_ce_n, bus_hold, done}, 5'b01100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ser_clk && mem_we_n && mem_ce_n && !bus_hold && !done,
        "R1 idle after reset", {ser_clk, mem_we_n, mem_ce_n, bus_hold, done}, 5'b01100);

    // Run 1: image mode, with a stray start and a mode flip mid-run.
    run_fill = 1'b0; fill_const = 1'b0;
    pulse_start();
    chk(bus_hold, "R7 hold after start", bus_hold, 1);
    while (exp_idx < 100) @(negedge clk);
    fill_const = 1'b1;
    pulse_start();  // R10: must be ignored
    while (done_cnt < 1) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(exp_idx == DEPTH, "R10 write count", exp_idx, DEPTH);
    verify_image(1'b0, "R4 image byte");
    chk(bmem[508] == 8'h00 && bmem[509] == 8'hFE, "R4 reset vector",
        {bmem[509], bmem[508]}, 16'hFE00);
    chk(!bus_hold, "R7 released when idle", bus_hold, 0);

    // Run 2: constant fill.
    clear_model();
    run_fill = 1'b1; fill_const = 1'b1;
    pulse_start();
    fill_const = 1'b0;  // R9: mode was latched at start
    while (done_cnt < 1) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_idx == DEPTH, "R9 fill write count", exp_idx, DEPTH);
    verify_image(1'b1, "R9 fill byte");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule